// File: doc/BRIEF.md
# BT.656 Single-Field Pixel Extractor

The block watches the 8-bit byte stream that a video decoder drives in BT.656 form, one byte per pixel clock. It spots the four-byte timing preambles, keeps track of which field is on the wire, and samples active pixel bytes only from lines of the selected field. Lines of the other field are passed over completely.

Inside a kept line, the 4:2:2 bytes are grouped four at a time. From each group the block keeps the blue-difference byte, the first luma byte and the red-difference byte, and drops the second luma byte. The result is one colour triple per pixel pair, so a 720-pixel line yields 360 samples, each marked by a one-cycle strobe.

Line and field markers travel with the data: an active-line level, a start-of-field pulse, an end-of-line pulse and a saturating line number. Colour conversion and frame storage downstream use these markers to place each sample.

Top module: `bt656_field_grab`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `pix_valid`, `line_active`, `sof`, `eol` and `line_num` are all 0.
- R2: A timing reference is recognised only when the bytes 0xFF, 0x00, 0x00 and a status byte arrive on consecutive cycles. A status byte of 0x80 (start of active video, kept field) raises `line_active` on the cycle after the status byte is sampled. A sequence with a byte missing does not.
- R3: A status byte of 0x9D (end of active video, kept field) that arrives while `line_active` is high lowers `line_active` and gives a one-cycle `eol` pulse, both on the cycle after the status byte is sampled.
- R4: Status bytes 0xC7 and 0xDA (start and end of active video of the other field) never raise `line_active`, `eol` or `pix_valid`, and bytes between them produce no samples.
- R5: Inside a kept line the bytes run Cb, Y, Cr, Y. On the cycle after each Cr byte is sampled, `pix_valid` is high for one cycle, and `cb_o`, `y_o`, `cr_o` hold that group's Cb, first Y and Cr. The second Y is discarded.
- R6: A kept line of N data bytes, with N a multiple of 4, produces exactly N/4 strobes. A 1440-byte line produces 360.
- R7: Bytes 0xFF, and 0x00 bytes that follow a 0xFF as part of a preamble prefix, are never taken as pixel data. The byte that breaks a partial preamble is taken as data in the group position where it falls, and the group position is unchanged by the reserved bytes.
- R8: `sof` pulses for one cycle, together with the rise of `line_active`, on the first 0x80 start code after reset or after a 0xC7 start code. Later 0x80 start codes in the same field do not pulse it.
- R9: `line_num` becomes 1 with `sof`, advances by one on each further 0x80 start code of the same field, and saturates at 253.
- R10: Every 0x80 start code clears the group position, so the first data byte after it is treated as Cb even if the previous line ended part-way through a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel byte clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | BT.656 byte stream |
| cb_o | output | 8 | Blue-difference byte of the latest triple |
| y_o | output | 8 | Luma byte of the latest triple |
| cr_o | output | 8 | Red-difference byte of the latest triple |
| pix_valid | output | 1 | One-cycle strobe: a new triple is on the outputs |
| line_active | output | 1 | High between start and end codes of a kept line |
| sof | output | 1 | One-cycle pulse at the first kept line of a field |
| eol | output | 1 | One-cycle pulse at the end of a kept line |
| line_num | output | 8 | Kept line number in the current field, saturating at 253 |

## Verification
The bench aims at the places where preamble bytes and pixel bytes meet. A stray 0xFF, or an 0xFF 0x00 prefix inside a line, must not shift the group position; a design that counted those bytes would swap chroma and luma in every later triple. A line that stops part-way through a group must not carry its leftover position into the next line, or the next line would start on a luma byte. Lines of the other field, and sequences with a byte missing, must leave the outputs quiet. `sof` and the line number must restart after a field change, and the line number must hold at 253 through an over-long field instead of wrapping to 0.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

    localparam int BYTE_W = 8;

    // status byte codes (kept field / skipped field)
    localparam logic [BYTE_W-1:0] KEEP_SAV = 8'h80;
    localparam logic [BYTE_W-1:0] KEEP_EAV = 8'h9D;
    localparam logic [BYTE_W-1:0] SKIP_SAV = 8'hC7;
    localparam logic [BYTE_W-1:0] SKIP_EAV = 8'hDA;
    localparam logic [BYTE_W-1:0] MARK_HI  = 8'hFF;
    localparam logic [BYTE_W-1:0] MARK_LO  = 8'h00;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_FF   = 2'd1,
        M_FF00 = 2'd2,
        M_STAT = 2'd3
    } match_st_t;

    typedef enum logic [1:0] {
        G_CB = 2'd0,
        G_Y0 = 2'd1,
        G_CR = 2'd2,
        G_Y1 = 2'd3
    } grp_pos_t;

    typedef struct packed {
        logic [BYTE_W-1:0] cb;
        logic [BYTE_W-1:0] y;
        logic [BYTE_W-1:0] cr;
    } triple_t;

    function automatic logic is_reserved(input logic [BYTE_W-1:0] b);
        return (b == MARK_HI) || (b == MARK_LO);
    endfunction

endpackage

// File: rtl/trs_matcher.sv
module trs_matcher
    import bt656_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] din,
    output logic              trs_hit,
    output logic              data_ok
);
    match_st_t st, st_nx;

    always_comb begin
        st_nx = M_IDLE;
        case (st)
            M_IDLE: st_nx = (din == MARK_HI) ? M_FF : M_IDLE;
            M_FF:   st_nx = (din == MARK_LO) ? M_FF00 :
                            (din == MARK_HI) ? M_FF : M_IDLE;
            M_FF00: st_nx = (din == MARK_LO) ? M_STAT :
                            (din == MARK_HI) ? M_FF : M_IDLE;
            M_STAT: st_nx = (din == MARK_HI) ? M_FF : M_IDLE;
            default: st_nx = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= M_IDLE;
        else     st <= st_nx;
    end

    assign trs_hit = (st == M_STAT);

    // a byte is pixel data unless it is a status byte or part of a prefix
    always_comb begin
        case (st)
            M_IDLE:  data_ok = (din != MARK_HI);
            M_FF,
            M_FF00:  data_ok = !is_reserved(din);
            default: data_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/field_tracker.sv
module field_tracker
    import bt656_pkg::*;
#(
    parameter int LINE_MAX = 253,
    parameter int LN_W     = $clog2(LINE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trs_hit,
    input  logic [BYTE_W-1:0] status,
    output logic              restart,
    output logic              line_active,
    output logic              sof,
    output logic              eol,
    output logic [LN_W-1:0]   line_num
);
    localparam logic [LN_W-1:0] LN_TOP = LN_W'(LINE_MAX);

    logic in_keep;
    logic hit_ksav, hit_keav, hit_ssav;

    assign hit_ksav = trs_hit && (status == KEEP_SAV);
    assign hit_keav = trs_hit && (status == KEEP_EAV);
    assign hit_ssav = trs_hit && (status == SKIP_SAV);
    assign restart  = hit_ksav;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_keep     <= 1'b0;
            line_active <= 1'b0;
            sof         <= 1'b0;
            eol         <= 1'b0;
            line_num    <= '0;
        end else begin
            sof <= 1'b0;
            eol <= 1'b0;
            if (hit_ksav) begin
                in_keep     <= 1'b1;
                line_active <= 1'b1;
                if (!in_keep) begin
                    sof      <= 1'b1;
                    line_num <= LN_W'(1);
                end else if (line_num < LN_TOP) begin
                    line_num <= line_num + 1'b1;
                end
            end else if (hit_keav) begin
                if (line_active) eol <= 1'b1;
                line_active <= 1'b0;
            end else if (hit_ssav) begin
                in_keep     <= 1'b0;
                line_active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/triple_packer.sv
module triple_packer
    import bt656_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    output triple_t           trip,
    output logic              valid
);
    grp_pos_t pos;
    logic [BYTE_W-1:0] hold_cb, hold_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= G_CB;
            hold_cb <= '0;
            hold_y  <= '0;
            trip    <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (restart) begin
                pos <= G_CB;
            end else if (take) begin
                case (pos)
                    G_CB: hold_cb <= din;
                    G_Y0: hold_y  <= din;
                    G_CR: begin
                        trip  <= '{cb: hold_cb, y: hold_y, cr: din};
                        valid <= 1'b1;
                    end
                    default: ;
                endcase
                pos <= grp_pos_t'(pos + 2'd1);
            end
        end
    end
endmodule

// File: rtl/bt656_field_grab.sv
module bt656_field_grab
    import bt656_pkg::*;
#(
    parameter int LINE_MAX = 253,
    localparam int LN_W    = $clog2(LINE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        din,
    output logic [7:0]        cb_o,
    output logic [7:0]        y_o,
    output logic [7:0]        cr_o,
    output logic              pix_valid,
    output logic              line_active,
    output logic              sof,
    output logic              eol,
    output logic [LN_W-1:0]   line_num
);
    logic    trs_hit, data_ok, restart;
    triple_t trip;

    trs_matcher u_match (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .trs_hit (trs_hit),
        .data_ok (data_ok)
    );

    field_tracker #(
        .LINE_MAX (LINE_MAX),
        .LN_W     (LN_W)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .trs_hit     (trs_hit),
        .status      (din),
        .restart     (restart),
        .line_active (line_active),
        .sof         (sof),
        .eol         (eol),
        .line_num    (line_num)
    );

    triple_packer u_pack (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .take    (line_active && data_ok),
        .din     (din),
        .trip    (trip),
        .valid   (pix_valid)
    );

    assign cb_o = trip.cb;
    assign y_o  = trip.y;
    assign cr_o = trip.cr;
endmodule

// File: rtl/bt656_field_grab_chk.sv
module bt656_field_grab_chk #(
    parameter int LINE_MAX = 253,
    parameter int LN_W     = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [7:0]      din,
    input logic            pix_valid,
    input logic            line_active,
    input logic            sof,
    input logic            eol,
    input logic [LN_W-1:0] line_num
);
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst < 3'd5) since_rst <= since_rst + 1'b1;
    end

    // R5: a strobe only follows a cycle inside a kept line
    p_valid_in_line_r5: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(line_active));

    // R5: strobes are single-cycle
    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> !pix_valid);

    // R3: end-of-line pulse coincides with the fall of the line flag
    p_eol_fall_r3: assert property (@(posedge clk) disable iff (rst)
        eol |-> (!line_active && $past(line_active)));

    // R8: start-of-field opens line one
    p_sof_line1_r8: assert property (@(posedge clk) disable iff (rst)
        sof |-> (line_active && line_num == LN_W'(1)));

    // R9: never beyond the saturation point
    p_line_sat_r9: assert property (@(posedge clk) disable iff (rst)
        line_num <= LN_W'(LINE_MAX));

    // R9: the counter only restarts at one or steps by one
    p_line_step_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_num) |-> (line_num == LN_W'(1) ||
                                line_num == $past(line_num) + 1'b1));

    // R2: a full kept start preamble opens the line
    p_sav_open_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && $past(din, 4) == 8'hFF && $past(din, 3) == 8'h00 &&
         $past(din, 2) == 8'h00 && $past(din) == 8'h80) |-> line_active);
endmodule

bind bt656_field_grab bt656_field_grab_chk #(
    .LINE_MAX (LINE_MAX),
    .LN_W     (LN_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .pix_valid   (pix_valid),
    .line_active (line_active),
    .sof         (sof),
    .eol         (eol),
    .line_num    (line_num)
);

// File: tb/tb_bt656_field_grab.sv
module tb_bt656_field_grab;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] cb_o, y_o, cr_o, line_num;
    logic       pix_valid, line_active, sof, eol;

    int checks = 0;
    int errs   = 0;
    int got    = 0;
    logic [23:0] exp_q[$];

    always #2.5 clk = ~clk;

    bt656_field_grab dut (
        .clk(clk), .rst(rst), .din(din),
        .cb_o(cb_o), .y_o(y_o), .cr_o(cr_o),
        .pix_valid(pix_valid), .line_active(line_active),
        .sof(sof), .eol(eol), .line_num(line_num)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pv(input int k);
        return 8'(16 + ((k * 37) % 208));
    endfunction

    // drive one byte; outputs observed reflect that byte's effect
    task automatic push(input logic [7:0] b);
        din = b;
        @(posedge clk);
        #1;
        if (pix_valid) begin
            got++;
            if (exp_q.size() == 0) chk("R5 unexpected strobe", {8'h0, cb_o, y_o, cr_o}, 32'h0);
            else chk("R5 triple", {8'h0, cb_o, y_o, cr_o}, {8'h0, exp_q.pop_front()});
        end
    endtask

    task automatic trs(input logic [7:0] xy);
        push(8'hFF); push(8'h00); push(8'h00); push(xy);
    endtask

    // body of a line: n bytes, triples expected only when keep
    task automatic body(input bit keep, input int n, input int base);
        for (int i = 0; i < n; i++) begin
            if (keep && (i % 4) == 2)
                exp_q.push_back({pv(base + i - 2), pv(base + i - 1), pv(base + i)});
            push(pv(base + i));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset outputs", {pix_valid, line_active, sof, eol, line_num}, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 after release", {pix_valid, line_active, sof, eol, line_num}, 0);

        // R2: broken preambles outside a line do nothing
        push(8'hFF); push(8'h00); push(8'h80);
        chk("R2 short prefix", line_active, 0);
        push(8'hFF); push(8'h00); push(8'h55); push(8'h00); push(8'h80);
        chk("R2 broken prefix", line_active, 0);

        // R4: other-field line ignored
        got = 0;
        trs(8'hC7);
        chk("R4 skip start", line_active, 0);
        body(1'b0, 40, 0);
        trs(8'hDA);
        chk("R4 skip end eol", {eol, line_active}, 0);
        chk("R4 no samples", got, 0);

        // R2/R8/R9: first kept line, with restart of matcher on FF
        push(8'hFF); push(8'h00); push(8'hFF); push(8'h00); push(8'h00); push(8'h80);
        chk("R2 start code opens line", line_active, 1);
        chk("R8 sof on first kept line", sof, 1);
        chk("R9 first line number", line_num, 1);
        got = 0;
        body(1'b1, 1440, 100);
        chk("R6 full line 360 strobes", got, 360);
        trs(8'h9D);
        chk("R3 eol pulse", {eol, line_active}, 2'b10);
        push(8'h33);
        chk("R3 eol single", eol, 0);

        // R8/R9: second kept line
        trs(8'h80);
        chk("R8 no sof on second line", sof, 0);
        chk("R9 second line number", line_num, 2);
        got = 0;
        body(1'b1, 16, 3000);
        chk("R6 short line", got, 4);
        trs(8'h9D);

        // R7: reserved bytes inside a line do not move the position
        trs(8'h80);
        exp_q.push_back({8'h11, 8'h22, 8'h33});
        exp_q.push_back({8'h44, 8'h55, 8'h66});
        got = 0;
        push(8'h11); push(8'hFF); push(8'h22); push(8'h33); push(8'h3A);
        push(8'h44); push(8'hFF); push(8'h00); push(8'h55); push(8'h66); push(8'h6B);
        chk("R7 reserved bytes skipped", got, 2);
        trs(8'h9D);

        // R10: line ending mid-group, next line starts on Cb
        trs(8'h80);
        got = 0;
        body(1'b1, 6, 4000);
        trs(8'h9D);
        trs(8'h80);
        body(1'b1, 4, 5000);
        chk("R10 fresh group after start", got, 2);
        trs(8'h9D);

        // R9: saturation
        for (int k = 0; k < 260; k++) begin
            trs(8'h80);
            body(1'b1, 4, 6000 + 4 * k);
            trs(8'h9D);
        end
        chk("R9 saturates", line_num, 253);

        // R8: field change restarts counting
        trs(8'hC7);
        chk("R4 other field closes", line_active, 0);
        trs(8'hDA);
        trs(8'h80);
        chk("R8 sof after field change", sof, 1);
        chk("R9 restart at one", line_num, 1);
        trs(8'h9D);
        chk("R5 all triples seen", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule